// File: doc/BRIEF.md
# Transmit Host Serial Sequencer

This block runs the transmit handshake between a medium-access controller and a spread-spectrum baseband. A rising edge on the transmit enable starts a sequence. The block first spends a fixed header period standing in for preamble and header generation. It then raises a ready flag and drives a bit clock at the rate the controller selected. It captures the controller's serial payload on one edge of that clock and packs the bits into bytes, least significant bit first.

The enable covers every payload bit except the last one. When the enable falls, the block still takes exactly one more bit. It then stops the bit clock, drops ready and holds the transmitter active for a fixed tail, so that the power amplifier can ramp down. After the tail it returns to standby. The timing uses a 44 MHz reference by default. At that frequency the four rate codes give 1, 2, 5.5 and 11 Mb/s, and the tail is 4 µs.

Top module: `tx_host_seq`

## Requirements
- R1: A sequence starts only on a 0-to-1 change of `tx_en` seen while idle. `tx_active` is 1 in the cycle after that edge. An enable that stays high when the block returns to idle starts nothing.
- R2: `tx_rdy` rises exactly HDR_CYC reference cycles after `tx_active` rises. `tx_rdy` is never 1 while `tx_active` is 0.
- R3: `bit_clk` stays at 0 whenever the payload phase is not running. The only exception is a single cycle right after the final capture. In the payload phase `bit_clk` starts low and toggles every half period. With default parameters the half period is 22, 11, 4 or 2 reference cycles for `rate_sel` codes 0, 1, 2 and 3. Its first transition comes one half period after `tx_rdy` rises.
- R4: `rate_sel` and `edge_sel` are taken when the sequence starts. Changing them later in the frame does not change the half period or the sampling edge.
- R5: With `edge_sel` = 0, `ser_in` is captured in the reference cycle where `bit_clk` changes from 0 to 1. With `edge_sel` = 1, it is captured where `bit_clk` changes from 1 to 0.
- R6: The first captured bit becomes bit 0 of a byte. After each eighth capture, `byte_vld` pulses for one cycle, and `byte_data` holds the byte in that same cycle.
- R7: After `tx_enable` falls during the payload phase, exactly one more bit is captured. This holds even when the fall is detected in the same cycle as a capture. `tx_rdy` is 0 from the cycle after that last capture.
- R8: After the last capture, `tx_active` stays 1 for exactly TAIL_CYC cycles and then drops to 0.
- R9: A rising edge of `tx_en` during the tail changes neither the tail length nor the return to idle.
- R10: If `tx_en` falls during the header period, the block goes straight to the tail. `tx_rdy` never rises, and `tx_active` then lasts TAIL_CYC cycles.
- R11: During reset, `tx_active`, `tx_rdy`, `bit_clk` and `byte_vld` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit envelope from the controller |
| rate_sel | input | 2 | Rate code, read at start |
| edge_sel | input | 1 | 0 = capture on rising bit clock, 1 = capture on falling bit clock |
| ser_in | input | 1 | Serial payload, LSB first |
| bit_clk | output | 1 | Payload bit clock to the controller |
| tx_rdy | output | 1 | Payload phase open |
| tx_active | output | 1 | Transmitter running, including the tail |
| byte_data | output | BYTE_W | Assembled payload byte |
| byte_vld | output | 1 | One-cycle strobe for `byte_data` |

## Verification
The pair that can fall in the same reference cycle is the detection of the enable's falling edge and a capture edge of the bit clock. When that happens, the capture must count, and exactly one further bit must follow. The stimulus table provokes this by holding the enable drop back to the reference cycle just before a capture edge. Frames that drop the enable right after a capture are the contrast case. Both kinds are judged on the same evidence: the two reassembled bytes, ready staying high until the sixteenth capture, and the tail length measured after it.

// File: rtl/txhs_pkg.sv
package txhs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR  = 3'd1,
        ST_DATA = 3'd2,
        ST_LAST = 3'd3,
        ST_TAIL = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        RATE_1M  = 2'd0,
        RATE_2M  = 2'd1,
        RATE_5M5 = 2'd2,
        RATE_11M = 2'd3
    } rate_e;

endpackage

// File: rtl/txhs_seq_fsm.sv
module txhs_seq_fsm
    import txhs_pkg::*;
#(
    parameter int HDR_CYC  = 192,
    parameter int TAIL_CYC = 176
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic [1:0] rate_sel,
    input  logic       edge_sel,
    input  logic       rise_evt,
    input  logic       fall_evt,
    output logic [1:0] rate_q,
    output logic       run,
    output logic       samp,
    output logic       clr,
    output logic       tx_rdy,
    output logic       tx_active
);
    localparam int MAXC  = (HDR_CYC > TAIL_CYC) ? HDR_CYC : TAIL_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_CYC - 1);
    localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(TAIL_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic             en_prev;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       rate;
        logic             neg_smp;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic en_rise, en_fall;

    always_comb begin
        en_rise = tx_en & ~fsm_q.en_prev;
        en_fall = ~tx_en & fsm_q.en_prev;
        samp    = fsm_q.neg_smp ? fall_evt : rise_evt;
        clr     = 1'b0;
        fsm_d         = fsm_q;
        fsm_d.en_prev = tx_en;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (en_rise) begin
                    fsm_d.st      = ST_HDR;
                    fsm_d.cnt     = '0;
                    fsm_d.rate    = rate_sel;
                    fsm_d.neg_smp = edge_sel;
                    clr           = 1'b1;
                end
            end
            ST_HDR: begin
                if (en_fall) begin
                    fsm_d.st  = ST_TAIL;
                    fsm_d.cnt = '0;
                end else if (fsm_q.cnt == HDR_LAST) begin
                    fsm_d.st  = ST_DATA;
                    fsm_d.cnt = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            ST_DATA: begin
                if (en_fall) begin
                    fsm_d.st = ST_LAST;
                end
            end
            ST_LAST: begin
                if (samp) begin
                    fsm_d.st  = ST_TAIL;
                    fsm_d.cnt = '0;
                end
            end
            ST_TAIL: begin
                if (fsm_q.cnt == TAIL_LAST) begin
                    fsm_d.st  = ST_IDLE;
                    fsm_d.cnt = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign run       = (fsm_q.st == ST_DATA) || (fsm_q.st == ST_LAST);
    assign tx_rdy    = run;
    assign tx_active = (fsm_q.st != ST_IDLE);
    assign rate_q    = fsm_q.rate;

endmodule

// File: rtl/txhs_bitclk.sv
module txhs_bitclk
    import txhs_pkg::*;
#(
    parameter int HALF_R0 = 22,
    parameter int HALF_R1 = 11,
    parameter int HALF_R2 = 4,
    parameter int HALF_R3 = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       bit_clk,
    output logic       rise_evt,
    output logic       fall_evt
);
    localparam int M01  = (HALF_R0 > HALF_R1) ? HALF_R0 : HALF_R1;
    localparam int M23  = (HALF_R2 > HALF_R3) ? HALF_R2 : HALF_R3;
    localparam int HMAX = (M01 > M23) ? M01 : M23;
    localparam int CW   = $clog2(HMAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } bclk_t;

    bclk_t bc_d, bc_q;
    logic [CW-1:0] half_last;
    logic          wrap;

    always_comb begin
        case (rate_e'(rate))
            RATE_1M:  half_last = CW'(HALF_R0 - 1);
            RATE_2M:  half_last = CW'(HALF_R1 - 1);
            RATE_5M5: half_last = CW'(HALF_R2 - 1);
            default:  half_last = CW'(HALF_R3 - 1);
        endcase
        wrap     = run && (bc_q.cnt == half_last);
        rise_evt = wrap && !bc_q.lvl;
        fall_evt = wrap && bc_q.lvl;
        bc_d     = bc_q;
        if (!run) begin
            bc_d.cnt = '0;
            bc_d.lvl = 1'b0;
        end else if (wrap) begin
            bc_d.cnt = '0;
            bc_d.lvl = ~bc_q.lvl;
        end else begin
            bc_d.cnt = bc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_q <= '0;
        end else begin
            bc_q <= bc_d;
        end
    end

    assign bit_clk = bc_q.lvl;

endmodule

// File: rtl/txhs_byte_asm.sv
module txhs_byte_asm #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              samp,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_vld
);
    localparam int BCW = $clog2(BYTE_W);
    localparam logic [BCW-1:0] BC_LAST = BCW'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [BCW-1:0]    bc;
        logic [BYTE_W-1:0] data;
        logic              vld;
    } asm_t;

    asm_t as_d, as_q;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        shifted  = {bit_in, as_q.sh[BYTE_W-1:1]};
        as_d     = as_q;
        as_d.vld = 1'b0;
        if (clr) begin
            as_d.bc = '0;
        end else if (samp) begin
            as_d.sh = shifted;
            if (as_q.bc == BC_LAST) begin
                as_d.bc   = '0;
                as_d.data = shifted;
                as_d.vld  = 1'b1;
            end else begin
                as_d.bc = as_q.bc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_q <= '0;
        end else begin
            as_q <= as_d;
        end
    end

    assign byte_data = as_q.data;
    assign byte_vld  = as_q.vld;

endmodule

// File: rtl/tx_host_seq.sv
module tx_host_seq #(
    parameter int HDR_CYC  = 192,
    parameter int TAIL_CYC = 176,
    parameter int HALF_R0  = 22,
    parameter int HALF_R1  = 11,
    parameter int HALF_R2  = 4,
    parameter int HALF_R3  = 2,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic [1:0]        rate_sel,
    input  logic              edge_sel,
    input  logic              ser_in,
    output logic              bit_clk,
    output logic              tx_rdy,
    output logic              tx_active,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_vld
);
    logic [1:0] rate_q;
    logic       run, samp, clr, rise_evt, fall_evt;

    txhs_seq_fsm #(
        .HDR_CYC  (HDR_CYC),
        .TAIL_CYC (TAIL_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .rate_sel  (rate_sel),
        .edge_sel  (edge_sel),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .rate_q    (rate_q),
        .run       (run),
        .samp      (samp),
        .clr       (clr),
        .tx_rdy    (tx_rdy),
        .tx_active (tx_active)
    );

    txhs_bitclk #(
        .HALF_R0 (HALF_R0),
        .HALF_R1 (HALF_R1),
        .HALF_R2 (HALF_R2),
        .HALF_R3 (HALF_R3)
    ) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .rate     (rate_q),
        .bit_clk  (bit_clk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    txhs_byte_asm #(
        .BYTE_W (BYTE_W)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .samp      (samp),
        .bit_in    (ser_in),
        .byte_data (byte_data),
        .byte_vld  (byte_vld)
    );

endmodule

// File: rtl/tx_host_seq_chk.sv
module tx_host_seq_chk #(
    parameter int HDR_CYC = 192
) (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic tx_rdy,
    input logic tx_active,
    input logic bit_clk,
    input logic byte_vld
);
    localparam int ACW = $clog2(HDR_CYC + 2);
    localparam logic [ACW-1:0] ACT_SAT = ACW'(HDR_CYC + 1);
    localparam logic [ACW-1:0] ACT_HDR = ACW'(HDR_CYC);

    logic [ACW-1:0] act_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_cnt <= '0;
        end else if (!tx_active) begin
            act_cnt <= '0;
        end else if (act_cnt != ACT_SAT) begin
            act_cnt <= act_cnt + 1'b1;
        end
    end

    AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_active) |-> $past(tx_en)); // R1
    AST_RDY_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_rdy) |-> (act_cnt == ACT_HDR)); // R2
    AST_RDY_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) tx_rdy |-> tx_active); // R2
    AST_BCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!tx_rdy && !$past(tx_rdy)) |-> !bit_clk); // R3
    AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) byte_vld |-> $past(tx_rdy)); // R6
    AST_RDY_END_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n) $fell(tx_rdy) |-> !$past(tx_en)); // R7

endmodule

bind tx_host_seq tx_host_seq_chk #(.HDR_CYC(HDR_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .tx_rdy    (tx_rdy),
    .tx_active (tx_active),
    .bit_clk   (bit_clk),
    .byte_vld  (byte_vld)
);

// File: tb/tx_host_seq_tb_top.sv
`timescale 1ns/1ps
module tx_host_seq_tb_top;
    localparam int HDR  = 192;
    localparam int TAIL = 176;

    // {rate[24:23], edge[22], drop lag[21:16], payload[15:0]}
    localparam logic [24:0] VEC [0:5] = '{
        {2'd0, 1'b0, 6'd0,  16'hA53C},
        {2'd1, 1'b1, 6'd0,  16'h0F81},
        {2'd2, 1'b0, 6'd7,  16'h6DB2},
        {2'd3, 1'b1, 6'd3,  16'h8001},
        {2'd3, 1'b0, 6'd0,  16'h5A5A},
        {2'd0, 1'b1, 6'd43, 16'h1234}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       edge_sel = 1'b0;
    logic       ser_in = 1'b0;
    logic       bit_clk, tx_rdy, tx_active, byte_vld;
    logic [7:0] byte_data;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] got [0:31];
    int  gcount = 0;

    always #4 clk = ~clk;

    tx_host_seq #(.HDR_CYC(HDR), .TAIL_CYC(TAIL)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .rate_sel  (rate_sel),
        .edge_sel  (edge_sel),
        .ser_in    (ser_in),
        .bit_clk   (bit_clk),
        .tx_rdy    (tx_rdy),
        .tx_active (tx_active),
        .byte_data (byte_data),
        .byte_vld  (byte_vld)
    );

    always @(negedge clk) begin
        if (rst_n && byte_vld) begin
            got[gcount % 32] <= byte_data;
            gcount <= gcount + 1;
        end
    end

    function automatic int half_of(input logic [1:0] rt);
        case (rt)
            2'd0: return 22;
            2'd1: return 11;
            2'd2: return 4;
            default: return 2;
        endcase
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_frame(input int vi);
        logic [24:0] v;
        logic [1:0]  rt;
        logic        fe;
        logic [15:0] pay;
        int lag, hp, sc, ss, since, guard, wait_n, per_bad, base, n;
        bit prev, early;
        v   = VEC[vi];
        rt  = v[24:23];
        fe  = v[22];
        lag = int'(v[21:16]);
        pay = v[15:0];
        hp  = half_of(rt);
        base = gcount;
        rate_sel = rt;
        edge_sel = fe;
        ser_in   = pay[0];
        tx_en    = 1'b1;
        wait_n = 0;
        do begin
            @(negedge clk);
            wait_n++;
        end while (!tx_rdy && wait_n < 1000);
        chk(wait_n == HDR + 1, "R2 ready delay after enable edge", wait_n, HDR + 1);
        chk(bit_clk == 1'b0, "R3 bit clock low at ready", int'(bit_clk), 0);
        rate_sel = ~rt;       // R4: later changes must not matter
        edge_sel = ~fe;
        prev = bit_clk; since = 0; ss = 0; sc = 0; guard = 0; per_bad = 0; early = 1'b0;
        while (sc < 16 && guard < 4000) begin
            @(negedge clk);
            guard++; since++; ss++;
            if (bit_clk != prev) begin
                if (since != hp) per_bad++;
                since = 0;
                if (bit_clk == !fe) begin
                    sc++;
                    ss = 0;
                    if (lag == 0 && sc == 15) tx_en = 1'b0;
                end else if (sc < 16) begin
                    ser_in = pay[sc];
                end
            end
            if (lag != 0 && sc == 14 && ss == lag) tx_en = 1'b0;
            if (sc < 16 && !tx_rdy) early = 1'b1;
            prev = bit_clk;
        end
        chk(sc == 16, "R7 sixteen captures observed", sc, 16);
        chk(per_bad == 0, "R3 R4 half period per latched rate", per_bad, 0);
        chk(!early, "R7 ready held until final bit", int'(early), 0);
        chk(!tx_rdy, "R7 ready dropped after final bit", int'(tx_rdy), 0);
        n = 0;
        while (tx_active && n < 5000) begin
            n++;
            @(negedge clk);
        end
        chk(n == TAIL, "R8 tail length", n, TAIL);
        chk(bit_clk == 1'b0, "R3 bit clock idle after frame", int'(bit_clk), 0);
        chk(gcount - base == 2, "R6 byte strobes per frame", gcount - base, 2);
        chk(got[base % 32] == pay[7:0], "R5 R6 first byte LSB first",
            int'(got[base % 32]), int'(pay[7:0]));
        chk(got[(base + 1) % 32] == pay[15:8], "R5 R6 second byte",
            int'(got[(base + 1) % 32]), int'(pay[15:8]));
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int n, quiet;
        bit seen;
        repeat (3) @(negedge clk);
        chk(!tx_active && !tx_rdy && !bit_clk && !byte_vld, "R11 outputs in reset",
            int'({tx_active, tx_rdy, bit_clk, byte_vld}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!tx_active, "R1 idle without edge", int'(tx_active), 0);

        for (int vi = 0; vi < 6; vi++) begin
            run_frame(vi);
        end

        // R10 abort in header, R9 edge during tail
        tx_en = 1'b1;
        repeat (50) @(negedge clk);
        chk(tx_active && !tx_rdy, "R10 header phase running", int'({tx_active, tx_rdy}), 2);
        tx_en = 1'b0;
        seen = 1'b0;
        @(negedge clk);
        n = 0;
        while (tx_active && n < 5000) begin
            n++;
            if (tx_rdy || bit_clk) seen = 1'b1;
            if (n == 20) tx_en = 1'b1;
            @(negedge clk);
        end
        chk(n == TAIL, "R10 R9 tail after header abort", n, TAIL);
        chk(!seen, "R10 no ready or bit clock on abort", int'(seen), 0);
        quiet = 0;
        repeat (60) begin
            @(negedge clk);
            if (tx_active) quiet++;
        end
        chk(quiet == 0, "R9 R1 held enable does not restart", quiet, 0);
        tx_en = 1'b0;
        @(negedge clk);
        chk(!tx_active, "R1 still idle after enable low", int'(tx_active), 0);
        tx_en = 1'b1;
        @(negedge clk);
        chk(tx_active, "R1 fresh edge starts sequence", int'(tx_active), 1);
        tx_en = 1'b0;
        repeat (TAIL + 10) @(negedge clk);
        chk(!tx_active, "R8 idle after tail", int'(tx_active), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule